// File: doc/BRIEF.md
# Transceiver Test-Mode Recovery Sequencer

This block sits on the controller side of an Ethernet line-interface device. It owns three of the device's control lines: loopback, full-duplex and squelch-disable. If loopback and full-duplex are both high, the device enters its production test mode. That can happen by accident while the controller boots, and the device then cannot pass traffic.

The sequencer drives a fixed, timed pattern on the three lines. The pattern enters test mode on purpose, which resets the device, and then leaves it cleanly. All delays are given in milliseconds and converted to clock cycles through the `CLK_HZ` parameter. One down-counter serves every step.

The sequence runs once by itself after a synchronous reset. Later it runs again on a rising edge of `start`. Outside the sequence, the lines follow normal-mode values supplied by software. A guard keeps those values from ever selecting test mode.

Top module: `xcvr_tm_recover`

## Requirements
- R1: While `rst` is high at a clock edge, `lpbk`, `fdx`, `sqd`, `busy` and `done` are all 0 after that edge, including when reset interrupts a sequence.
- R2: At the first clock edge after `rst` falls, the sequence starts without any `start` request. `busy` goes to 1 and the lines become `lpbk`=0, `fdx`=1, `sqd`=0.
- R3: That first step lasts exactly PREP_MS*CLK_HZ/1000 cycles. Then `lpbk` rises while `fdx` stays 1.
- R4: Exactly HOLD_MS*CLK_HZ/1000 cycles after `lpbk` rises, `fdx` falls while `lpbk` stays 1.
- R5: Exactly EXIT_MS*CLK_HZ/1000 cycles after `fdx` falls, `lpbk` is released. At that same edge `busy` falls and `done` is 1 for exactly one cycle.
- R6: `sqd` is 0 in every cycle in which `busy` is 1.
- R7: `start` acts only on a 0-to-1 transition while idle. A rising edge while `busy` is 1 is ignored and does not change the step timing. Holding `start` high after `done` starts nothing.
- R8: While idle, `fdx` and `sqd` equal `norm_fdx` and `norm_sqd` as sampled at the previous clock edge. `lpbk` equals `norm_lpbk` from that edge whenever `norm_fdx` was 0.
- R9: While idle, if `norm_lpbk` and `norm_fdx` are both 1, `lpbk` is driven 0 and `fdx` is driven 1.
- R10: `lpbk` and `fdx` are both 1 only during the step between R3 and R4, never while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to run the sequence, rising-edge triggered |
| norm_lpbk | input | 1 | Software loopback value for normal mode |
| norm_fdx | input | 1 | Software full-duplex value for normal mode |
| norm_sqd | input | 1 | Software squelch-disable value for normal mode |
| lpbk | output | 1 | Loopback control line to the device |
| fdx | output | 1 | Full-duplex control line to the device |
| sqd | output | 1 | Squelch-disable control line to the device |
| busy | output | 1 | High from the first step until the done pulse |
| done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
A wrong step state shows at once on the line pattern. The three lines and `busy` change only at step boundaries, so a skipped or repeated step produces a wrong combination in the very next cycle. A wrong counter load or decrement does not show in the pattern itself; it shows as a transition that comes early or late by some number of cycles. The bench therefore checks the output pattern in every cycle of each step, not only at its ends. This catches both a one-cycle slip and a state that holds for too long.

// File: rtl/xcvr_tm_recover.sv
module xcvr_tm_recover #(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned PREP_MS = 1,
  parameter int unsigned HOLD_MS = 300,
  parameter int unsigned EXIT_MS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic norm_lpbk,
  input  logic norm_fdx,
  input  logic norm_sqd,
  output logic lpbk,
  output logic fdx,
  output logic sqd,
  output logic busy,
  output logic done
);
  localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
  localparam int unsigned PREP_CYC   = PREP_MS * CYC_PER_MS;
  localparam int unsigned HOLD_CYC   = HOLD_MS * CYC_PER_MS;
  localparam int unsigned EXIT_CYC   = EXIT_MS * CYC_PER_MS;
  localparam int unsigned MAX_A      = (PREP_CYC > HOLD_CYC) ? PREP_CYC : HOLD_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > EXIT_CYC) ? MAX_A : EXIT_CYC;
  localparam int unsigned CNT_W      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] PREP_LD = CNT_W'(PREP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LD = CNT_W'(EXIT_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_TEST, S_EXIT} step_t;

  step_t            st;
  logic [CNT_W-1:0] cnt;
  logic             arm, start_q;
  logic             go, safe_lp, cnt_zero;

  assign go       = arm | (start & ~start_q);
  assign safe_lp  = norm_lpbk & ~norm_fdx;
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      lpbk    <= 1'b0;
      fdx     <= 1'b0;
      sqd     <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      arm     <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= start;
      done    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            st   <= S_PREP;
            cnt  <= PREP_LD;
            busy <= 1'b1;
            arm  <= 1'b0;
            lpbk <= 1'b0;
            fdx  <= 1'b1;
            sqd  <= 1'b0;
          end else begin
            lpbk <= safe_lp;
            fdx  <= norm_fdx;
            sqd  <= norm_sqd;
          end
        end
        S_PREP: begin
          if (cnt_zero) begin
            st   <= S_TEST;
            cnt  <= HOLD_LD;
            lpbk <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TEST: begin
          if (cnt_zero) begin
            st  <= S_EXIT;
            cnt <= EXIT_LD;
            fdx <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_EXIT: begin
          if (cnt_zero) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
            lpbk <= safe_lp;
            fdx  <= norm_fdx;
            sqd  <= norm_sqd;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_tm_recover_chk.sv
module xcvr_tm_recover_chk (
  input logic clk,
  input logic rst,
  input logic lpbk,
  input logic fdx,
  input logic sqd,
  input logic busy,
  input logic done
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !lpbk && !fdx && !sqd && !busy && !done);

  p_lp_rise_fdx_high_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lpbk) && busy |-> fdx);

  p_fdx_fall_lp_high_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(fdx) && busy |-> lpbk);

  p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  p_sqd_low_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sqd);

  p_test_combo_busy_r10: assert property (@(posedge clk) disable iff (rst)
    lpbk && fdx |-> busy);
endmodule

bind xcvr_tm_recover xcvr_tm_recover_chk u_chk (
  .clk(clk), .rst(rst), .lpbk(lpbk), .fdx(fdx), .sqd(sqd),
  .busy(busy), .done(done)
);

// File: tb/sim_xcvr_tm_recover.sv
`timescale 1ns/1ps
module sim_xcvr_tm_recover;
  localparam int unsigned CLK_HZ = 8000;
  localparam int unsigned PREP_MS = 2;
  localparam int unsigned HOLD_MS = 300;
  localparam int unsigned EXIT_MS = 500;
  localparam int PREP_N = PREP_MS * CLK_HZ / 1000;
  localparam int HOLD_N = HOLD_MS * CLK_HZ / 1000;
  localparam int EXIT_N = EXIT_MS * CLK_HZ / 1000;

  // {lpbk,fdx,sqd,busy,done}
  localparam logic [4:0] PH_PREP = 5'b01010;
  localparam logic [4:0] PH_TEST = 5'b11010;
  localparam logic [4:0] PH_EXIT = 5'b10010;

  // {norm_lpbk,norm_fdx,norm_sqd, exp lpbk,fdx,sqd}
  localparam logic [5:0] IDLE_VEC [8] = '{
    6'b000_000, 6'b001_001, 6'b010_010, 6'b011_011,
    6'b100_100, 6'b101_101, 6'b110_010, 6'b111_011
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic norm_lpbk = 1'b0, norm_fdx = 1'b0, norm_sqd = 1'b1;
  logic lpbk, fdx, sqd, busy, done;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  xcvr_tm_recover #(.CLK_HZ(CLK_HZ), .PREP_MS(PREP_MS), .HOLD_MS(HOLD_MS),
                    .EXIT_MS(EXIT_MS)) u0 (
    .clk(clk), .rst(rst), .start(start), .norm_lpbk(norm_lpbk),
    .norm_fdx(norm_fdx), .norm_sqd(norm_sqd), .lpbk(lpbk), .fdx(fdx),
    .sqd(sqd), .busy(busy), .done(done));

  function automatic logic [4:0] outs();
    return {lpbk, fdx, sqd, busy, done};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [4:0] act,
                       input logic [4:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic phase(input logic [4:0] exp, input int n, input string tag);
    bit ok = 1'b1;
    logic [4:0] seen = exp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outs() !== exp && ok) begin ok = 1'b0; seen = outs(); end
    end
    check(ok, tag, seen, exp);
  endtask

  task automatic finish_seq(input logic [4:0] idle_exp, input string tag);
    @(negedge clk);
    check(outs() === {idle_exp[4:2], 2'b01}, {tag, " R5 done pulse"}, outs(),
          {idle_exp[4:2], 2'b01});
    @(negedge clk);
    check(outs() === idle_exp, {tag, " R5 done single"}, outs(), idle_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outs() === 5'b0, "R1 reset outputs", outs(), 5'b0);
    rst = 1'b0;
    phase(PH_PREP, PREP_N, "R2 R3 R6 first step after reset");
    phase(PH_TEST, HOLD_N, "R3 R4 R10 test step");
    phase(PH_EXIT, EXIT_N, "R4 R5 R6 exit step");
    finish_seq(5'b00100, "seq1");

    for (int v = 0; v < 8; v++) begin
      {norm_lpbk, norm_fdx, norm_sqd} = IDLE_VEC[v][5:3];
      @(negedge clk);
      check(outs() === {IDLE_VEC[v][2:0], 2'b00},
            (v >= 6) ? "R9 R10 idle guard" : "R8 idle follow",
            outs(), {IDLE_VEC[v][2:0], 2'b00});
    end

    {norm_lpbk, norm_fdx, norm_sqd} = 3'b010;
    start = 1'b1;
    phase(PH_PREP, PREP_N, "R7 start edge first step");
    phase(PH_TEST, 1, "R7 test step a");
    start = 1'b0;
    phase(PH_TEST, 1, "R7 test step b");
    start = 1'b1;
    phase(PH_TEST, HOLD_N - 2, "R7 edge while busy ignored");
    phase(PH_EXIT, EXIT_N, "R5 R7 exit step 2");
    finish_seq(5'b01000, "seq2");
    phase(5'b01000, 20, "R7 held start no restart");

    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    phase(PH_PREP, PREP_N, "R7 R3 third run first step");
    phase(PH_TEST, 5, "R10 third run test");
    rst = 1'b1;
    @(negedge clk);
    check(outs() === 5'b0, "R1 reset mid sequence", outs(), 5'b0);
    rst = 1'b0;
    phase(PH_PREP, PREP_N, "R2 auto restart after reset");
    phase(PH_TEST, 3, "R3 lpbk rise after restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule